// File: doc/BRIEF.md
# Sensor Bus Channel Mode Controller

This block is the per-channel control state machine of a master on a two-wire sensor bus. It keeps the channel in one of four modes: off, command/response, periodic collection or buffer-check. It acts on write strobes from the register file for the control, periodic-setup, clear and transmit-buffer registers. In command/response mode it starts queued commands while keeping a minimum spacing between command starts. It can also send a burst of discovery pulses to slaves that are still unaddressed.

In periodic mode the block issues broadcast-read starts, one per manual request or one per slot when automatic repetition is on, each after a programmable delay. Its outputs are single-cycle start strobes for the command serializer and the broadcast generator, a discovery pulse level for the bus driver, the current mode and the transmit-empty status. Bus encoding and the analog stage sit outside the block.

Timing comes from four parameters: the slot length `SLOT_CYC` (command spacing and broadcast period), the delay step `DLY_UNIT`, the discovery period `DISC_PER` and the discovery pulse width `DISC_HIGH`. At a 10 MHz clock these are 5000, 5, 1250 and 160.

Top module: `chan_mode_ctrl`

## Requirements
- R1: After reset, `mode` is 0 (encoding: 0 off, 1 command/response, 2 periodic, 3 buffer-check), `tx_empty` is 1, and `cmd_start`, `brc_start` and `disc_pulse` are 0.
- R2: A control write with `ctrl_en`=1 moves the mode from off to command/response. A control write with `ctrl_en`=0 moves it from command/response to off and drops any queued command, so `tx_empty` returns to 1 and that command is never started.
- R3: A control write with `ctrl_chk`=2'b11 enters buffer-check from any mode except periodic, whatever `ctrl_en` and `ctrl_pulses` hold. Buffer-check is left only by a clear.
- R4: A clear write with `clr_val`=8'hFF returns every mode and timer to its reset state on the next cycle. A clear write with any other value has no effect.
- R5: In command/response mode, with no command started in the last `SLOT_CYC` cycles, a transmit write makes `tx_empty` 0 on the following cycle and raises `cmd_start` for one cycle on the cycle after that.
- R6: A transmit write that arrives less than `SLOT_CYC` cycles after the last command start is held, with `tx_empty`=0, and starts exactly `SLOT_CYC` cycles after that last start.
- R7: Transmit writes while `tx_empty` is 0, or while the mode is not command/response, are ignored.
- R8: A periodic-setup write with `per_en`=1 moves command/response into periodic mode. In periodic mode, control writes and transmit writes have no effect, and only a clear leaves the mode.
- R9: In periodic mode, a setup write with `per_brc`=1 and `per_auto`=0 pulses `brc_start` 1 + `per_dly`×`DLY_UNIT` cycles after the write. A broadcast request outside periodic mode is ignored.
- R10: A setup write that sets `per_auto` in periodic mode triggers a broadcast at once and again every `SLOT_CYC` cycles, each delayed as in R9, until auto is cleared. Auto writes made outside periodic mode are ignored.
- R11: In command/response mode, a control write with `ctrl_en`=1, `ctrl_chk`≠2'b11 and a nonzero `ctrl_pulses` value N raises `disc_pulse` N times. Each pulse is `DISC_HIGH` cycles long, pulses start `DISC_PER` cycles apart, and the first starts on the cycle after the write. N=0 gives no pulses, and a request made while a burst is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_chk | input | 2 | Buffer-check request field |
| ctrl_en | input | 1 | Channel enable field |
| ctrl_pulses | input | 3 | Discovery pulse count field |
| per_wr | input | 1 | Periodic-setup register write strobe |
| per_brc | input | 1 | Manual broadcast request |
| per_auto | input | 1 | Automatic broadcast enable |
| per_en | input | 1 | Periodic mode enable |
| per_dly | input | 8 | Broadcast delay in units of `DLY_UNIT` cycles |
| clr_wr | input | 1 | Clear register write strobe |
| clr_val | input | 8 | Clear key value |
| tx_wr | input | 1 | Transmit buffer write strobe |
| mode | output | 2 | Current channel mode |
| tx_empty | output | 1 | No command is waiting to start |
| cmd_start | output | 1 | One-cycle command start strobe |
| brc_start | output | 1 | One-cycle broadcast-read start strobe |
| disc_pulse | output | 1 | Discovery pulse level |

## Verification
The bench builds the block with `SLOT_CYC`=40, `DLY_UNIT`=5, `DISC_PER`=20 and `DISC_HIGH`=4. These values put the command spacing, a full automatic broadcast period and a three-pulse discovery burst within tens of cycles. The short slot lets a long random run of transmit writes hit the queued, immediate and ignored cases many times against a reference model. With the delay step kept at its real value, nonzero delays give latencies that are easy to tell apart.

// File: rtl/chan_mode_pkg.sv
package chan_mode_pkg;

    localparam int CNT_W = 3;
    localparam int DLY_W = 8;
    localparam logic [7:0] CLR_KEY = 8'hFF;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_CR   = 2'b01,
        MODE_PER  = 2'b10,
        MODE_BCHK = 2'b11
    } chan_mode_e;

    typedef struct packed {
        logic [1:0]       chk;
        logic             enable;
        logic [CNT_W-1:0] pulses;
    } ctrl_fields_t;

    function automatic int unsigned dly_cycles(input logic [DLY_W-1:0] d,
                                               input int unsigned unit);
        return int'(d) * unit;
    endfunction

endpackage

// File: rtl/cmc_mode_fsm.sv
module cmc_mode_fsm
    import chan_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       ctrl_wr,
    input  logic [1:0] ctrl_chk,
    input  logic       ctrl_en,
    input  logic       per_wr,
    input  logic       per_en,
    output chan_mode_e mode_o
);

    chan_mode_e st, nxt;

    always_comb begin
        nxt = st;
        if (clr)
            nxt = MODE_OFF;
        else if (ctrl_wr && st != MODE_PER && ctrl_chk == 2'b11)
            nxt = MODE_BCHK;
        else if (ctrl_wr && st == MODE_OFF && ctrl_en)
            nxt = MODE_CR;
        else if (ctrl_wr && st == MODE_CR && !ctrl_en)
            nxt = MODE_OFF;
        else if (per_wr && st == MODE_CR && per_en)
            nxt = MODE_PER;
    end

    always_ff @(posedge clk) begin
        if (rst) st <= MODE_OFF;
        else     st <= nxt;
    end

    assign mode_o = st;

    p_clear_r4: assert property (@(posedge clk) disable iff (rst)
        clr |=> st == MODE_OFF);
    p_chk_priority_r3: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && ctrl_chk == 2'b11 && st != MODE_PER && !clr) |=> st == MODE_BCHK);
    p_chk_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (st == MODE_BCHK && !clr) |=> st == MODE_BCHK);
    p_per_lock_r8: assert property (@(posedge clk) disable iff (rst)
        (st == MODE_PER && !clr) |=> st == MODE_PER);

endmodule

// File: rtl/cmc_cmd_sched.sv
module cmc_cmd_sched
    import chan_mode_pkg::*;
#(
    parameter int SLOT_CYC = 5000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  chan_mode_e mode,
    input  logic       tx_wr,
    output logic       cmd_start_o,
    output logic       tx_empty_o
);

    localparam int GW = $clog2(SLOT_CYC + 1);

    logic          pend;
    logic [GW-1:0] guard;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pend        <= 1'b0;
            guard       <= '0;
            cmd_start_o <= 1'b0;
        end else begin
            cmd_start_o <= 1'b0;
            if (guard != '0) guard <= guard - 1'b1;
            if (mode != MODE_CR) begin
                pend <= 1'b0;
            end else if (pend && guard == '0) begin
                cmd_start_o <= 1'b1;
                pend        <= 1'b0;
                guard       <= GW'(SLOT_CYC - 1);
            end else if (!pend && tx_wr) begin
                pend <= 1'b1;
            end
        end
    end

    assign tx_empty_o = !pend;

    p_drop_r7: assert property (@(posedge clk) disable iff (rst)
        (pend && mode != MODE_CR) |=> !pend);
    p_launch_r6: assert property (@(posedge clk) disable iff (rst)
        (pend && guard == '0 && mode == MODE_CR && !clr) |=> cmd_start_o);
    p_start_mode_r5: assert property (@(posedge clk) disable iff (rst)
        cmd_start_o |-> $past(mode) == MODE_CR);

endmodule

// File: rtl/cmc_brc_gen.sv
module cmc_brc_gen
    import chan_mode_pkg::*;
#(
    parameter int SLOT_CYC = 5000,
    parameter int DLY_UNIT = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  chan_mode_e       mode,
    input  logic             per_wr,
    input  logic             per_brc,
    input  logic             per_auto,
    input  logic [DLY_W-1:0] per_dly,
    output logic             brc_start_o
);

    localparam int DW = $clog2((2**DLY_W - 1) * DLY_UNIT + 1);
    localparam int PW = $clog2(SLOT_CYC + 1);

    logic             auto_q, armed;
    logic [DLY_W-1:0] dly_q;
    logic [DW-1:0]    wcnt;
    logic [PW-1:0]    pcnt;

    logic             wr_per, wr_cfg, auto_n, man_trig, auto_rise, auto_tick, trig;
    logic [DLY_W-1:0] dly_n;

    always_comb begin
        wr_per    = per_wr && mode == MODE_PER;
        wr_cfg    = per_wr && (mode == MODE_CR || mode == MODE_PER);
        dly_n     = wr_cfg ? per_dly : dly_q;
        auto_n    = wr_per ? per_auto : auto_q;
        man_trig  = wr_per && per_brc && !per_auto;
        auto_rise = auto_n && !auto_q;
        auto_tick = auto_q && auto_n && pcnt == '0;
        trig      = man_trig || auto_rise || auto_tick;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            auto_q      <= 1'b0;
            armed       <= 1'b0;
            dly_q       <= '0;
            wcnt        <= '0;
            pcnt        <= '0;
            brc_start_o <= 1'b0;
        end else begin
            brc_start_o <= 1'b0;
            dly_q       <= dly_n;
            auto_q      <= auto_n;
            if (auto_rise || auto_tick)
                pcnt <= PW'(SLOT_CYC - 1);
            else if (auto_q && pcnt != '0)
                pcnt <= pcnt - 1'b1;
            if (trig) begin
                armed <= 1'b1;
                wcnt  <= DW'(dly_cycles(dly_n, DLY_UNIT));
            end else if (armed) begin
                if (wcnt == '0) begin
                    brc_start_o <= 1'b1;
                    armed       <= 1'b0;
                end else begin
                    wcnt <= wcnt - 1'b1;
                end
            end
        end
    end

    p_brc_in_per_r9: assert property (@(posedge clk) disable iff (rst)
        brc_start_o |-> mode == MODE_PER);
    p_auto_off_r10: assert property (@(posedge clk) disable iff (rst)
        (mode != MODE_PER) |-> !auto_q);

endmodule

// File: rtl/cmc_disc_burst.sv
module cmc_disc_burst
    import chan_mode_pkg::*;
#(
    parameter int DISC_PER  = 1250,
    parameter int DISC_HIGH = 160
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  chan_mode_e   mode,
    input  logic         ctrl_wr,
    input  ctrl_fields_t ctrl_f,
    output logic         pulse_o
);

    localparam int PHW = (DISC_PER > 1) ? $clog2(DISC_PER) : 1;

    logic [CNT_W-1:0] left;
    logic [PHW-1:0]   ph;
    logic             busy, launch;

    assign busy   = left != '0;
    assign launch = mode == MODE_CR && ctrl_wr && ctrl_f.chk != 2'b11 &&
                    ctrl_f.enable && ctrl_f.pulses != '0 && !busy;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            left <= '0;
            ph   <= '0;
        end else if (mode != MODE_CR) begin
            left <= '0;
            ph   <= '0;
        end else if (launch) begin
            left <= ctrl_f.pulses;
            ph   <= '0;
        end else if (busy) begin
            if (ph == PHW'(DISC_PER - 1)) begin
                ph   <= '0;
                left <= left - 1'b1;
            end else begin
                ph <= ph + 1'b1;
            end
        end
    end

    assign pulse_o = busy && (32'(ph) < DISC_HIGH);

    p_no_reload_r11: assert property (@(posedge clk) disable iff (rst)
        (busy && !clr) |=> left <= $past(left));
    p_abort_r11: assert property (@(posedge clk) disable iff (rst)
        (mode != MODE_CR) |=> !busy);

endmodule

// File: rtl/chan_mode_ctrl.sv
module chan_mode_ctrl
    import chan_mode_pkg::*;
#(
    parameter int SLOT_CYC  = 5000,
    parameter int DLY_UNIT  = 5,
    parameter int DISC_PER  = 1250,
    parameter int DISC_HIGH = 160
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ctrl_wr,
    input  logic [1:0] ctrl_chk,
    input  logic       ctrl_en,
    input  logic [2:0] ctrl_pulses,
    input  logic       per_wr,
    input  logic       per_brc,
    input  logic       per_auto,
    input  logic       per_en,
    input  logic [7:0] per_dly,
    input  logic       clr_wr,
    input  logic [7:0] clr_val,
    input  logic       tx_wr,
    output logic [1:0] mode,
    output logic       tx_empty,
    output logic       cmd_start,
    output logic       brc_start,
    output logic       disc_pulse
);

    chan_mode_e   cur_mode;
    ctrl_fields_t ctrl_f;
    logic         clr;

    assign clr    = clr_wr && clr_val == CLR_KEY;
    assign ctrl_f = '{chk: ctrl_chk, enable: ctrl_en, pulses: ctrl_pulses};
    assign mode   = cur_mode;

    cmc_mode_fsm u_fsm (
        .clk(clk), .rst(rst), .clr(clr),
        .ctrl_wr(ctrl_wr), .ctrl_chk(ctrl_chk), .ctrl_en(ctrl_en),
        .per_wr(per_wr), .per_en(per_en),
        .mode_o(cur_mode)
    );

    cmc_cmd_sched #(.SLOT_CYC(SLOT_CYC)) u_sched (
        .clk(clk), .rst(rst), .clr(clr), .mode(cur_mode),
        .tx_wr(tx_wr), .cmd_start_o(cmd_start), .tx_empty_o(tx_empty)
    );

    cmc_brc_gen #(.SLOT_CYC(SLOT_CYC), .DLY_UNIT(DLY_UNIT)) u_brc (
        .clk(clk), .rst(rst), .clr(clr), .mode(cur_mode),
        .per_wr(per_wr), .per_brc(per_brc), .per_auto(per_auto),
        .per_dly(per_dly), .brc_start_o(brc_start)
    );

    cmc_disc_burst #(.DISC_PER(DISC_PER), .DISC_HIGH(DISC_HIGH)) u_disc (
        .clk(clk), .rst(rst), .clr(clr), .mode(cur_mode),
        .ctrl_wr(ctrl_wr), .ctrl_f(ctrl_f), .pulse_o(disc_pulse)
    );

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mode == 2'b00 && tx_empty && !cmd_start && !brc_start));

endmodule

// File: tb/tb_chan_mode_ctrl.sv
module tb_chan_mode_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int SLOT = 40;
    localparam int UNIT = 5;
    localparam int PER  = 20;
    localparam int HIGH = 4;

    logic       clk = 1'b0;
    logic       rst;
    logic       ctrl_wr = 0, ctrl_en = 0, per_wr = 0, per_brc = 0, per_auto = 0, per_en = 0;
    logic       clr_wr = 0, tx_wr = 0;
    logic [1:0] ctrl_chk = 0;
    logic [2:0] ctrl_pulses = 0;
    logic [7:0] per_dly = 0, clr_val = 0;
    logic [1:0] mode;
    logic       tx_empty, cmd_start, brc_start, disc_pulse;

    int nchk = 0, nfail = 0, ecnt = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chan_mode_ctrl #(.SLOT_CYC(SLOT), .DLY_UNIT(UNIT), .DISC_PER(PER), .DISC_HIGH(HIGH)) dut (
        .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_chk(ctrl_chk), .ctrl_en(ctrl_en),
        .ctrl_pulses(ctrl_pulses), .per_wr(per_wr), .per_brc(per_brc), .per_auto(per_auto),
        .per_en(per_en), .per_dly(per_dly), .clr_wr(clr_wr), .clr_val(clr_val), .tx_wr(tx_wr),
        .mode(mode), .tx_empty(tx_empty), .cmd_start(cmd_start), .brc_start(brc_start),
        .disc_pulse(disc_pulse)
    );

    task automatic tick;
        @(posedge clk);
        ecnt++;
        @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [1:0] chk, input logic en, input logic [2:0] n);
        ctrl_wr = 1; ctrl_chk = chk; ctrl_en = en; ctrl_pulses = n;
        tick();
        ctrl_wr = 0;
    endtask

    task automatic wr_per(input logic b, input logic a, input logic e, input logic [7:0] d);
        per_wr = 1; per_brc = b; per_auto = a; per_en = e; per_dly = d;
        tick();
        per_wr = 0;
    endtask

    task automatic wr_clr(input logic [7:0] v);
        clr_wr = 1; clr_val = v;
        tick();
        clr_wr = 0;
    endtask

    task automatic wr_tx;
        tx_wr = 1;
        tick();
        tx_wr = 0;
    endtask

    function automatic logic pick(input int which);
        return (which == 0) ? cmd_start : (which == 1) ? brc_start : disc_pulse;
    endfunction

    task automatic wait_hi(input int which, input int limit, output int n);
        n = 0;
        do begin
            tick();
            n++;
        end while (!pick(which) && n < limit);
    endtask

    task automatic count_hi(input int which, input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            tick();
            if (pick(which)) cnt++;
        end
    endtask

    task automatic count_disc(input int n, output int rises, output int highs);
        logic prev;
        prev = 0; rises = 0; highs = 0;
        for (int i = 0; i < n; i++) begin
            if (disc_pulse) highs++;
            if (disc_pulse && !prev) rises++;
            prev = disc_pulse;
            tick();
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int n, c, r1, h1, r2, h2, s0, last_s, old;
        logic mpend, exp_s;
        void'($urandom(32'd20240611));
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        check("R1 mode", mode, 0);
        check("R1 tx_empty", tx_empty, 1);
        check("R1 strobes", {cmd_start, brc_start, disc_pulse}, 0);

        // R7 transmit ignored while off
        wr_tx();
        count_hi(0, 5, c);
        check("R7 no start when off", c, 0);
        check("R7 tx_empty when off", tx_empty, 1);

        // R2 enable
        wr_ctrl(2'b00, 1, 3'd0);
        check("R2 enable", mode, 1);

        // R5 immediate start
        wr_tx();
        check("R5 tx_empty after write", tx_empty, 0);
        check("R5 no start yet", cmd_start, 0);
        tick();
        check("R5 start", cmd_start, 1);
        check("R5 tx_empty after start", tx_empty, 1);
        s0 = ecnt;

        // R6 queued, R7 second write ignored
        wr_tx();
        check("R6 tx_empty queued", tx_empty, 0);
        wr_tx();
        wait_hi(0, 3 * SLOT, n);
        check("R6 spacing", ecnt - s0, SLOT);
        count_hi(0, 2 * SLOT, c);
        check("R7 extra write ignored", c, 0);

        // R2 disable drops queued command
        wr_tx();
        tick();
        check("R2 start before disable", cmd_start, 1);
        wr_tx();
        check("R2 queued", tx_empty, 0);
        wr_ctrl(2'b00, 0, 3'd0);
        check("R2 disabled", mode, 0);
        tick();
        check("R2 queue dropped", tx_empty, 1);
        count_hi(0, 2 * SLOT, c);
        check("R2 no late start", c, 0);

        // R5 R6 R7 random transmit traffic against a model
        wr_ctrl(2'b00, 1, 3'd0);
        repeat (SLOT) tick();
        mpend = 0; last_s = -100000;
        for (int i = 0; i < 400; i++) begin
            tx_wr = ($urandom_range(0, 5) == 0);
            @(posedge clk);
            ecnt++;
            old = mpend; exp_s = 0;
            if (old && (ecnt - last_s >= SLOT)) begin exp_s = 1; mpend = 0; last_s = ecnt; end
            if (!old && tx_wr) mpend = 1;
            @(negedge clk);
            tx_wr = 0;
            check("R6 random cmd_start", cmd_start, exp_s);
            check("R7 random tx_empty", tx_empty, !mpend);
        end
        repeat (2 * SLOT) tick();

        // R11 discovery burst
        wr_ctrl(2'b00, 1, 3'd3);
        count_disc(3 * PER + 10, r1, h1);
        check("R11 pulse count", r1, 3);
        check("R11 high cycles", h1, 3 * HIGH);
        wr_ctrl(2'b00, 1, 3'd0);
        count_disc(2 * PER, r1, h1);
        check("R11 zero count", r1, 0);
        wr_ctrl(2'b00, 1, 3'd2);
        count_disc(5, r1, h1);
        wr_ctrl(2'b00, 1, 3'd3);
        count_disc(3 * PER + 10, r2, h2);
        check("R11 busy request ignored", r1 + r2, 2);
        check("R11 busy high cycles", h1 + h2, 2 * HIGH);

        // R3 buffer-check priority and hold, R4 clear key
        wr_ctrl(2'b11, 0, 3'd5);
        check("R3 enter buffer-check", mode, 3);
        check("R3 no discovery", disc_pulse, 0);
        wr_ctrl(2'b00, 1, 3'd0);
        check("R3 hold", mode, 3);
        wr_clr(8'h7F);
        check("R4 wrong key ignored", mode, 3);
        wr_clr(8'hFF);
        check("R4 clear", mode, 0);
        check("R4 clear tx_empty", tx_empty, 1);

        // R8 periodic entry, R9 R10 requests ignored on entry
        wr_ctrl(2'b00, 1, 3'd0);
        wr_per(1, 1, 1, 8'd0);
        check("R8 enter periodic", mode, 2);
        count_hi(1, SLOT + 10, c);
        check("R10 auto on entry ignored", c, 0);
        wr_ctrl(2'b00, 0, 3'd0);
        check("R8 disable blocked", mode, 2);
        wr_ctrl(2'b11, 1, 3'd0);
        check("R8 buffer-check blocked", mode, 2);
        wr_tx();
        check("R8 tx ignored", tx_empty, 1);
        count_hi(0, 5, c);
        check("R8 no cmd start", c, 0);

        // R9 manual broadcast delay
        wr_per(1, 0, 1, 8'd3);
        wait_hi(1, 200, n);
        check("R9 delay 3", n, 1 + 3 * UNIT);
        wr_per(1, 0, 1, 8'd0);
        wait_hi(1, 200, n);
        check("R9 delay 0", n, 1);

        // R10 automatic broadcasts
        wr_per(0, 1, 1, 8'd2);
        wait_hi(1, 200, n);
        check("R10 first auto", n, 1 + 2 * UNIT);
        wait_hi(1, 200, n);
        check("R10 auto period", n, SLOT);
        wr_per(0, 0, 1, 8'd2);
        count_hi(1, 2 * SLOT, c);
        check("R10 auto stopped", c, 0);
        wr_clr(8'hFF);
        check("R8 clear leaves periodic", mode, 0);

        // R9 R10 requests outside periodic mode
        wr_ctrl(2'b00, 1, 3'd0);
        wr_per(1, 0, 0, 8'd0);
        wr_per(0, 1, 0, 8'd0);
        count_hi(1, SLOT + 10, c);
        check("R9 request outside periodic", c, 0);
        wr_per(0, 0, 1, 8'd0);
        count_hi(1, SLOT + 10, c);
        check("R10 earlier auto write ignored", c, 0);
        wr_clr(8'hFF);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule